// File: doc/BRIEF.md
# Maskable Edge-Triggered Interrupt Controller

This block gathers eight event sources into one active-low interrupt line for a processor. Six sources are per-channel frame strobes, three on the transmit side and three on the receive side. The other two are summary error events. Each summary is the OR of several error inputs, and each of those error inputs has its own enable bit.

Every source is edge-sensitive. A rising edge on a source sets a sticky request bit. A mask register decides which request bits may pull the interrupt line low. Software clears request bits by writing zeros to a clear register. A separate error status register records every individual error edge and empties itself when the processor reads it.

The processor reaches all registers through a simple synchronous bus. It has one shared address, write and read strobes, write data, and combinational read data. Reset is synchronous and active high. Reset masks every source, disables every error input and empties the request and status registers. Reads return the reset contents while reset is held.

Top module: `irq_ctl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the mask register reads 0xFF, the error enable, request and error status registers read 0x00, and `irq_n` is 1. Reads remain available during reset.
- R2: The request register (read at address 0x1F) holds bit 0..2 = transmit frame events of channels 1..3, bit 3..5 = receive frame events of channels 1..3, bit 6 = transmit error summary, bit 7 = receive error summary. A 0-to-1 transition on an input sets its bit two clock edges later. The bit stays set until it is cleared. An input held high does not set the bit again after it has been cleared.
- R3: The mask register (address 0xEB) is written and read as a whole byte. A 1 in bit i keeps request bit i from driving `irq_n`. A masked source still sets its request bit.
- R4: A write to the clear register (address 0xEC) clears every request bit whose data bit is 0. Data bits that are 1 leave their request bits unchanged.
- R5: `irq_n` is 0 exactly when at least one request bit is set whose mask bit is 0. It returns to 1 in the cycle after the last such bit is cleared or masked.
- R6: The error input vector `err_src` has bits 0..2 = transmit channel 1..3 errors, bits 3..5 = receive channel 1..3 errors, and bit 6 = clock recovery loop error. Request bit 6 is set by a rising edge on any of bits 0..2 whose enable bit is 1. Request bit 7 is set by a rising edge on any of bits 3..6 whose enable bit is 1.
- R7: The error enable register (address 0x3D) is read and written with the same bit layout as `err_src`. Bit 7 is not stored and reads 0.
- R8: The error status register (address 0x3C) latches a rising edge on each `err_src` bit, whether that bit is enabled or not. A read of this register (`rd_en` high with this address) returns its contents and clears it at the same clock edge.
- R9: If a new edge for a source arrives in the same cycle as a clear write with a 0 in that source's bit, the request bit stays set.
- R10: If an error edge arrives in the same cycle as a read of the error status register, that error's bit is set after the read. The other previously latched bits are cleared.
- R11: Reads of the clear register address and of any unmapped address return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 8 | Register address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; clears the error status register when it is addressed |
| rd_data | output | 8 | Combinational read data for `addr` |
| frame_ev | input | 6 | Frame event inputs: bits 0..2 transmit channels, bits 3..5 receive channels |
| err_src | input | 7 | Error inputs: bits 0..2 transmit, bits 3..5 receive, bit 6 clock recovery loop |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The bench steps through every frame source with its mask bit both set and cleared. It also steps through every error input with its enable both on and off, and predicts the request pattern, the status byte and the interrupt level from the bit maps above. A level-sensitive design fails the held-input case, because it sets the bit again right after the clear. The bench also lines up a new edge with a clear write, and a new error edge with a status read. A design that gives priority to the clear loses the event. A masked source is checked for still setting its request bit. A design that masks before the request register would show an empty request byte. The bench writes all ones to the clear register and checks that nothing is cleared. This catches a design that clears on write-one.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int N_CH     = 3;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 8;
    localparam int FRAME_W  = 2 * N_CH;
    localparam int ERR_W    = 2 * N_CH + 1;
    localparam int SRC_W    = FRAME_W + 2;
    localparam int TX_ERR_W = N_CH;
    localparam int RX_ERR_W = ERR_W - N_CH;

    localparam logic [ADDR_W-1:0] A_MASK  = 8'hEB;
    localparam logic [ADDR_W-1:0] A_REQ   = 8'h1F;
    localparam logic [ADDR_W-1:0] A_CLR   = 8'hEC;
    localparam logic [ADDR_W-1:0] A_ERRST = 8'h3C;
    localparam logic [ADDR_W-1:0] A_ERREN = 8'h3D;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MASK,
        SEL_REQ,
        SEL_CLR,
        SEL_ERRST,
        SEL_ERREN
    } reg_sel_e;

    typedef struct packed {
        logic              tx_hit;
        logic              rx_hit;
    } err_sum_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            A_MASK:  return SEL_MASK;
            A_REQ:   return SEL_REQ;
            A_CLR:   return SEL_CLR;
            A_ERRST: return SEL_ERRST;
            A_ERREN: return SEL_ERREN;
            default: return SEL_NONE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] widen_err(input logic [ERR_W-1:0] v);
        logic [DATA_W-1:0] r;
        r = '0;
        r[ERR_W-1:0] = v;
        return r;
    endfunction

endpackage

// File: rtl/edge_rise.sv
module edge_rise #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] rise
);

    logic [W-1:0] smp_q;
    logic [W-1:0] prv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q <= '0;
            prv_q <= '0;
        end else begin
            smp_q <= din;
            prv_q <= smp_q;
        end
    end

    assign rise = smp_q & ~prv_q;

endmodule

// File: rtl/err_combine.sv
module err_combine
    import irq_pkg::*;
(
    input  logic [ERR_W-1:0] err_rise,
    input  logic [ERR_W-1:0] err_en,
    output err_sum_t         sum
);

    logic [ERR_W-1:0] gated;

    assign gated      = err_rise & err_en;
    assign sum.tx_hit = |gated[TX_ERR_W-1:0];
    assign sum.rx_hit = |gated[ERR_W-1:TX_ERR_W];

endmodule

// File: rtl/req_bank.sv
module req_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    input  logic [N-1:0] mask,
    output logic [N-1:0] req_q,
    output logic         irq_n
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                req_q[i] <= 1'b0;
            end else if (set_vec[i]) begin
                req_q[i] <= 1'b1;
            end else if (clr_vec[i]) begin
                req_q[i] <= 1'b0;
            end
        end
    end

    assign irq_n = ~|(req_q & ~mask);

endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic [FRAME_W-1:0] frame_ev,
    input  logic [ERR_W-1:0]  err_src,
    output logic              irq_n
);

    reg_sel_e           sel;
    logic [FRAME_W-1:0] frame_rise;
    logic [ERR_W-1:0]   err_rise;
    err_sum_t           err_sum;
    logic [SRC_W-1:0]   set_vec;
    logic [SRC_W-1:0]   clr_vec;
    logic [SRC_W-1:0]   req_q;
    logic [SRC_W-1:0]   mask_q;
    logic [ERR_W-1:0]   en_q;
    logic [ERR_W-1:0]   status_q;
    logic               wr_mask;
    logic               wr_en_reg;
    logic               rd_status;

    assign sel       = decode_addr(addr);
    assign wr_mask   = wr_en && (sel == SEL_MASK);
    assign wr_en_reg = wr_en && (sel == SEL_ERREN);
    assign rd_status = rd_en && (sel == SEL_ERRST);

    edge_rise #(.W(FRAME_W)) u_frame_edge (
        .clk  (clk),
        .rst  (rst),
        .din  (frame_ev),
        .rise (frame_rise)
    );

    edge_rise #(.W(ERR_W)) u_err_edge (
        .clk  (clk),
        .rst  (rst),
        .din  (err_src),
        .rise (err_rise)
    );

    err_combine u_comb (
        .err_rise (err_rise),
        .err_en   (en_q),
        .sum      (err_sum)
    );

    assign set_vec = {err_sum.rx_hit, err_sum.tx_hit, frame_rise};
    assign clr_vec = (wr_en && (sel == SEL_CLR)) ? ~wr_data[SRC_W-1:0] : '0;

    req_bank #(.N(SRC_W)) u_req (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .mask    (mask_q),
        .req_q   (req_q),
        .irq_n   (irq_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            en_q   <= '0;
        end else begin
            if (wr_mask) begin
                mask_q <= wr_data[SRC_W-1:0];
            end
            if (wr_en_reg) begin
                en_q <= wr_data[ERR_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else begin
            status_q <= (rd_status ? '0 : status_q) | err_rise;
        end
    end

    always_comb begin
        rd_data = '0;
        case (sel)
            SEL_MASK:  rd_data[SRC_W-1:0] = mask_q;
            SEL_REQ:   rd_data[SRC_W-1:0] = req_q;
            SEL_ERRST: rd_data = widen_err(status_q);
            SEL_ERREN: rd_data = widen_err(en_q);
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk
    import irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en,
    input logic              irq_n,
    input logic [SRC_W-1:0]  req_q,
    input logic [SRC_W-1:0]  mask_q,
    input logic [SRC_W-1:0]  set_vec,
    input logic [ERR_W-1:0]  err_rise,
    input logic [ERR_W-1:0]  status_q
);

    AST_IRQ_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> (req_q != '0)) else $error("irq without request"); // R5

    AST_FULL_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '1) |-> irq_n) else $error("irq while fully masked"); // R3

    AST_REQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == A_CLR) |=> (($past(req_q) & ~req_q) == '0))
        else $error("request dropped without clear"); // R2

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_CLR) |=>
        ((req_q & ~$past(wr_data[SRC_W-1:0]) & ~$past(set_vec)) == '0))
        else $error("clear-by-zero missed"); // R4

    AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> (($past(set_vec) & ~req_q) == '0))
        else $error("new edge lost"); // R9

    AST_STATUS_KEEPS_EDGE: assert property (@(posedge clk) disable iff (rst)
        (err_rise != '0) |=> (($past(err_rise) & ~status_q) == '0))
        else $error("error edge not latched"); // R10

    AST_STATUS_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == A_ERRST) |=> ((status_q & ~$past(err_rise)) == '0))
        else $error("status not cleared by read"); // R8

endmodule

bind irq_ctl irq_ctl_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .irq_n    (irq_n),
    .req_q    (req_q),
    .mask_q   (mask_q),
    .set_vec  (set_vec),
    .err_rise (err_rise),
    .status_q (status_q)
);

// File: tb/irq_ctl_tb_top.sv
module irq_ctl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] addr = 8'h00;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [5:0] frame_ev = '0;
    logic [6:0] err_src = '0;
    logic       irq_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    irq_ctl dut_i (
        .clk      (clk),
        .rst      (rst),
        .addr     (addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .frame_ev (frame_ev),
        .err_src  (err_src),
        .irq_n    (irq_n)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic nclk(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic rd_clr(input logic [7:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_frame(input int i);
        frame_ev[i] = 1'b1;
        @(negedge clk);
        frame_ev[i] = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_err(input int j);
        err_src[j] = 1'b1;
        @(negedge clk);
        err_src[j] = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] exp_req;

        nclk(3);
        // R1: reads during reset
        rd(8'hEB, d); check("R1 mask in reset", d, 8'hFF);
        rd(8'h1F, d); check("R1 req in reset", d, 8'h00);
        rd(8'h3D, d); check("R1 enable in reset", d, 8'h00);
        rd(8'h3C, d); check("R1 status in reset", d, 8'h00);
        check("R1 irq_n in reset", {7'd0, irq_n}, 8'h01);
        rst = 1'b0;
        @(negedge clk);
        rd(8'hEB, d); check("R1 mask after reset", d, 8'hFF);
        check("R1 irq_n after reset", {7'd0, irq_n}, 8'h01);

        // R11: unmapped and clear address read zero
        rd(8'hEC, d); check("R11 clear reg read", d, 8'h00);
        rd(8'h00, d); check("R11 unmapped read", d, 8'h00);
        rd(8'h3E, d); check("R11 unmapped read 3E", d, 8'h00);

        // R3: mask write/read
        wr(8'hEB, 8'h5A);
        rd(8'hEB, d); check("R3 mask readback", d, 8'h5A);

        // R2/R3/R5: sweep frame sources with mask on and off
        for (int i = 0; i < 6; i++) begin
            for (int m = 0; m < 2; m++) begin
                wr(8'hEB, m ? 8'hFF : 8'h00);
                pulse_frame(i);
                rd(8'h1F, d); check($sformatf("R2 req src%0d m%0d", i, m), d, 8'(1 << i));
                check($sformatf("R5 irq src%0d m%0d", i, m), {7'd0, irq_n}, 8'(m));
                wr(8'hEC, ~8'(1 << i));
                rd(8'h1F, d); check($sformatf("R4 cleared src%0d", i), d, 8'h00);
                check($sformatf("R5 irq off src%0d", i), {7'd0, irq_n}, 8'h01);
            end
        end

        // R7: enable register
        wr(8'h3D, 8'hFF);
        rd(8'h3D, d); check("R7 enable bit7 zero", d, 8'h7F);

        // R6/R8: sweep error inputs with enable on and off
        wr(8'hEB, 8'h00);
        for (int j = 0; j < 7; j++) begin
            for (int e = 0; e < 2; e++) begin
                wr(8'h3D, e ? 8'(1 << j) : 8'h00);
                pulse_err(j);
                exp_req = e ? ((j < 3) ? 8'h40 : 8'h80) : 8'h00;
                rd(8'h1F, d); check($sformatf("R6 req err%0d en%0d", j, e), d, exp_req);
                check($sformatf("R6 irq err%0d en%0d", j, e), {7'd0, irq_n}, 8'(e == 0));
                rd_clr(8'h3C, d); check($sformatf("R8 status err%0d en%0d", j, e), d, 8'(1 << j));
                rd(8'h3C, d); check($sformatf("R8 status cleared err%0d", j), d, 8'h00);
                wr(8'hEC, 8'h3F);
                rd(8'h1F, d); check($sformatf("R4 err clear %0d", j), d, 8'h00);
            end
        end
        wr(8'h3D, 8'h00);

        // R2: held-high input does not set again
        frame_ev[2] = 1'b1;
        nclk(3);
        rd(8'h1F, d); check("R2 held first set", d, 8'h04);
        wr(8'hEC, 8'hFB);
        nclk(4);
        rd(8'h1F, d); check("R2 held no reset", d, 8'h00);
        frame_ev[2] = 1'b0;
        nclk(2);

        // R4: ones in clear register do nothing
        pulse_frame(0);
        pulse_frame(1);
        wr(8'hEC, 8'hFF);
        rd(8'h1F, d); check("R4 clear ones noop", d, 8'h03);
        // R5: masking one of two pending
        wr(8'hEB, 8'h01);
        check("R5 one unmasked", {7'd0, irq_n}, 8'h00);
        wr(8'hEB, 8'h03);
        check("R5 both masked", {7'd0, irq_n}, 8'h01);
        rd(8'h1F, d); check("R3 masked still pending", d, 8'h03);
        wr(8'hEC, 8'hFD);
        rd(8'h1F, d); check("R4 partial clear", d, 8'h01);
        wr(8'hEB, 8'h00);

        // R9: edge in same cycle as clear of that bit
        frame_ev[0] = 1'b1;
        @(negedge clk);
        frame_ev[0] = 1'b0;
        wr(8'hEC, 8'hFE);
        rd(8'h1F, d); check("R9 edge beats clear", d, 8'h01);
        wr(8'hEC, 8'hFE);
        rd(8'h1F, d); check("R9 later clear works", d, 8'h00);

        // R10: error edge in same cycle as status read
        pulse_err(1);
        err_src[0] = 1'b1;
        @(negedge clk);
        err_src[0] = 1'b0;
        rd_clr(8'h3C, d); check("R10 read value", d, 8'h02);
        rd(8'h3C, d); check("R10 new edge kept", d, 8'h01);
        rd_clr(8'h3C, d);

        // R1: reset again restores masks and enables
        wr(8'h3D, 8'h7F);
        rst = 1'b1;
        @(negedge clk);
        rd(8'hEB, d); check("R1 re-reset mask", d, 8'hFF);
        rd(8'h3D, d); check("R1 re-reset enable", d, 8'h00);
        rst = 1'b0;
        @(negedge clk);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule